// File: doc/BRIEF.md
# Semaphore wait and update unit

This unit guards the issue of one instruction at a time with a bank of counting semaphores. It reads the synchronisation fields of a bundle header (bytes 4 to 11 of the bundle), holds the instruction until the chosen semaphore reaches a threshold, and then grants issue. When the execution side reports completion, it applies the header's update to the chosen semaphore and becomes ready for the next header.

The threshold is either the 32-bit slot itself or the value of a register whose id sits in the low bits of that slot; the register is read through a read port that the unit drives. The same slot carries the operand of the update, while the increment and decrement updates ignore it. Other agents may bump any semaphore by one through an external port in any cycle, and a registered observation port returns one semaphore's value.

Top module: `sema_sync_unit`

## Requirements
- R1: `hdr_sync` carries bundle bytes 4..11: bits 7:0 wait mode, bits 15:8 wait semaphore index, bits 23:16 update mode, bits 31:24 update semaphore index, bits 63:32 the shared slot (byte 8 in bits 39:32). Only the low log2(N_SEM) bits of each index byte select a semaphore.
- R2: After reset every semaphore is 0, `hdr_ready` is 1, `issue_grant` and `sync_err` are 0 and `sem_rd_data` is 0.
- R3: `issue_grant` is a one-cycle pulse; with wait mode 0 (no wait) it rises in the cycle after the cycle that accepted the header.
- R4: Wait mode 1: the grant is held while the semaphore, compared unsigned, is below the slot value and comes one cycle after it reaches it.
- R5: Wait mode 2: `reg_rd_id` is the slot's low REG_ID_W bits and the threshold is `reg_rd_val`, re-read every cycle while waiting.
- R6: On `op_done` while an instruction is granted, update mode 0 leaves the semaphore alone, mode 1 sets it to the slot and mode 2 adds the slot (modulo 2^SEM_W).
- R7: Update mode 3 adds one and mode 4 subtracts one (modulo 2^SEM_W); the slot value has no effect on either.
- R8: A pulse on `ext_inc_valid` adds one to semaphore `ext_inc_idx`; in the same cycle as an update to the same semaphore both apply (result = update result + 1).
- R9: A wait mode above 2 or an update mode above 4 makes the grant come without waiting, with `sync_err` high in the grant cycle, and no update is made at completion.
- R10: Only one instruction is in flight: `hdr_ready` is high only when idle, a header is taken on `hdr_valid` while ready, and `op_done` outside the granted phase is ignored.
- R11: `sem_rd_data` shows, one clock after it is sampled, the value semaphore `sem_rd_idx` held before that clock's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Unit idle, header can be taken |
| hdr_sync | input | 64 | Bundle bytes 4..11 (R1 layout) |
| issue_grant | output | 1 | One-cycle permission to issue |
| sync_err | output | 1 | Unknown mode seen, pulses with the grant |
| op_done | input | 1 | Granted instruction has completed |
| reg_rd_id | output | REG_ID_W | Register id for the wait threshold |
| reg_rd_val | input | SEM_W | Value of register `reg_rd_id` |
| ext_inc_valid | input | 1 | External increment request |
| ext_inc_idx | input | log2(N_SEM) | Semaphore to increment |
| sem_rd_idx | input | log2(N_SEM) | Semaphore to observe |
| sem_rd_data | output | SEM_W | Registered value of the observed semaphore |

## Verification
Every cycle, assertions check that the grant is a single pulse, that an error only appears with a grant, that a taken header drops ready, that an immediate wait never releases below its threshold, and that set, decrement and external increment land in the bank with the expected value. What the assertions cannot show is the full arithmetic of coincident updates, the re-reading of a changing register threshold, the slot being ignored by increment and decrement, and the dropped update after an unknown mode; the bench's reference model, compared every clock, and its directed scenarios cover those.

// File: rtl/sema_pkg.sv
package sema_pkg;
  // normalised wait kinds
  localparam logic [1:0] WAIT_NONE   = 2'd0;
  localparam logic [1:0] WAIT_GE_IMM = 2'd1;
  localparam logic [1:0] WAIT_GE_REG = 2'd2;
  localparam logic [1:0] WAIT_BAD    = 2'd3;

  // normalised update kinds
  localparam logic [2:0] UPD_NONE = 3'd0;
  localparam logic [2:0] UPD_SET  = 3'd1;
  localparam logic [2:0] UPD_ADD  = 3'd2;
  localparam logic [2:0] UPD_INC  = 3'd3;
  localparam logic [2:0] UPD_DEC  = 3'd4;

  localparam int SYNC_BYTES = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BUSY
  } sync_state_t;
endpackage

// File: rtl/sema_hdr_decode.sv
module sema_hdr_decode
  import sema_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int SEM_W = 32
) (
  input  logic [SYNC_BYTES*8-1:0] sync_f,
  output logic [1:0]              wait_kind,
  output logic [IDX_W-1:0]        wait_idx,
  output logic [2:0]              upd_kind,
  output logic [IDX_W-1:0]        upd_idx,
  output logic [SEM_W-1:0]        slot,
  output logic                    bad
);
  logic [7:0] fb [SYNC_BYTES];

  for (genvar g = 0; g < SYNC_BYTES; g++) begin : g_byte
    assign fb[g] = sync_f[8*g +: 8];
  end

  // upper index bits select nothing
  logic unused_idx_hi;
  assign unused_idx_hi = ^{fb[1][7:IDX_W], fb[3][7:IDX_W]};

  assign wait_idx = fb[1][IDX_W-1:0];
  assign upd_idx  = fb[3][IDX_W-1:0];
  assign slot     = SEM_W'({fb[7], fb[6], fb[5], fb[4]});

  always_comb begin
    case (fb[0])
      8'd0:    wait_kind = WAIT_NONE;
      8'd1:    wait_kind = WAIT_GE_IMM;
      8'd2:    wait_kind = WAIT_GE_REG;
      default: wait_kind = WAIT_BAD;
    endcase
    if (fb[2] <= 8'd4) upd_kind = fb[2][2:0];
    else               upd_kind = UPD_NONE;
    bad = (wait_kind == WAIT_BAD) || (fb[2] > 8'd4);
  end
endmodule

// File: rtl/sema_bank.sv
module sema_bank
  import sema_pkg::*;
#(
  parameter int N_SEM = 32,
  parameter int SEM_W = 32,
  localparam int IDX_W = $clog2(N_SEM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] wait_idx,
  output logic [SEM_W-1:0] wait_val,
  input  logic             upd_v,
  input  logic [2:0]       upd_op,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [SEM_W-1:0] upd_arg,
  input  logic             ext_v,
  input  logic [IDX_W-1:0] ext_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SEM_W-1:0] rd_data
);
  logic [SEM_W-1:0] mem [N_SEM];
  logic [SEM_W-1:0] nxt [N_SEM];

  function automatic logic [SEM_W-1:0] apply_op(
    input logic [SEM_W-1:0] old, input logic [2:0] op, input logic [SEM_W-1:0] arg);
    case (op)
      UPD_SET: return arg;
      UPD_ADD: return old + arg;
      UPD_INC: return old + SEM_W'(1);
      UPD_DEC: return old - SEM_W'(1);
      default: return old;
    endcase
  endfunction

  assign wait_val = mem[wait_idx];

  always_comb begin
    for (int i = 0; i < N_SEM; i++) begin
      nxt[i] = mem[i];
      if (upd_v && upd_idx == IDX_W'(i)) nxt[i] = apply_op(mem[i], upd_op, upd_arg);
      // external bump stacks on top of any internal update
      nxt[i] = nxt[i] + SEM_W'(ext_v && ext_idx == IDX_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_SEM; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      for (int i = 0; i < N_SEM; i++) mem[i] <= nxt[i];
      rd_data <= mem[rd_idx];
    end
  end

  // R8: a lone external bump adds exactly one
  p_ext_bump_r8: assert property (@(posedge clk) disable iff (rst)
    ext_v && !(upd_v && upd_idx == ext_idx)
    |=> mem[$past(ext_idx)] == $past(mem[ext_idx]) + SEM_W'(1));

  // R7: decrement without a coincident bump
  p_dec_r7: assert property (@(posedge clk) disable iff (rst)
    upd_v && upd_op == UPD_DEC && !(ext_v && ext_idx == upd_idx)
    |=> mem[$past(upd_idx)] == $past(mem[upd_idx]) - SEM_W'(1));

  // R6: set lands the argument
  p_set_r6: assert property (@(posedge clk) disable iff (rst)
    upd_v && upd_op == UPD_SET && !(ext_v && ext_idx == upd_idx)
    |=> mem[$past(upd_idx)] == $past(upd_arg));
endmodule

// File: rtl/sema_seq.sv
module sema_seq
  import sema_pkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int SEM_W    = 32,
  parameter int REG_ID_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hdr_valid,
  output logic                hdr_ready,
  input  logic [1:0]          d_wait_kind,
  input  logic [IDX_W-1:0]    d_wait_idx,
  input  logic [2:0]          d_upd_kind,
  input  logic [IDX_W-1:0]    d_upd_idx,
  input  logic [SEM_W-1:0]    d_slot,
  input  logic                d_bad,
  output logic                issue_grant,
  output logic                sync_err,
  input  logic                op_done,
  output logic [REG_ID_W-1:0] reg_rd_id,
  input  logic [SEM_W-1:0]    reg_rd_val,
  output logic [IDX_W-1:0]    wait_idx,
  input  logic [SEM_W-1:0]    wait_val,
  output logic                upd_v,
  output logic [2:0]          upd_op,
  output logic [IDX_W-1:0]    upd_idx,
  output logic [SEM_W-1:0]    upd_arg
);
  sync_state_t          state;
  logic [1:0]           wk_q;
  logic [2:0]           uk_q;
  logic [IDX_W-1:0]     wi_q, ui_q;
  logic [SEM_W-1:0]     slot_q;
  logic                 bad_q;
  logic                 cond, release_now;

  assign hdr_ready = (state == ST_IDLE);
  assign wait_idx  = wi_q;
  assign reg_rd_id = slot_q[REG_ID_W-1:0];
  assign upd_op    = uk_q;
  assign upd_idx   = ui_q;
  assign upd_arg   = slot_q;
  assign upd_v     = (state == ST_BUSY) && op_done && !bad_q && (uk_q != UPD_NONE);

  always_comb begin
    case (wk_q)
      WAIT_GE_IMM: cond = (wait_val >= slot_q);
      WAIT_GE_REG: cond = (wait_val >= reg_rd_val);
      default:     cond = 1'b1;
    endcase
    release_now = bad_q || cond;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      wk_q        <= WAIT_NONE;
      uk_q        <= UPD_NONE;
      wi_q        <= '0;
      ui_q        <= '0;
      slot_q      <= '0;
      bad_q       <= 1'b0;
      issue_grant <= 1'b0;
      sync_err    <= 1'b0;
    end else begin
      issue_grant <= 1'b0;
      sync_err    <= 1'b0;
      case (state)
        ST_IDLE: if (hdr_valid) begin
          wk_q   <= d_wait_kind;
          uk_q   <= d_upd_kind;
          wi_q   <= d_wait_idx;
          ui_q   <= d_upd_idx;
          slot_q <= d_slot;
          bad_q  <= d_bad;
          state  <= ST_WAIT;
        end
        ST_WAIT: if (release_now) begin
          issue_grant <= 1'b1;
          sync_err    <= bad_q;
          state       <= ST_BUSY;
        end
        ST_BUSY: if (op_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: grant lasts one cycle
  p_grant_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    issue_grant |=> !issue_grant);

  // R9: error only together with a grant
  p_err_with_grant_r9: assert property (@(posedge clk) disable iff (rst)
    sync_err |-> issue_grant);

  // R10: a taken header closes the door
  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (rst)
    hdr_valid && hdr_ready |=> !hdr_ready);

  // R4: below threshold no grant follows
  p_hold_below_r4: assert property (@(posedge clk) disable iff (rst)
    state == ST_WAIT && wk_q == WAIT_GE_IMM && !bad_q && wait_val < slot_q
    |=> !issue_grant);
endmodule

// File: rtl/sema_sync_unit.sv
module sema_sync_unit
  import sema_pkg::*;
#(
  parameter int N_SEM    = 32,
  parameter int SEM_W    = 32,
  parameter int REG_ID_W = 8,
  localparam int IDX_W   = $clog2(N_SEM),
  localparam int SYNC_W  = SYNC_BYTES * 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hdr_valid,
  output logic                hdr_ready,
  input  logic [SYNC_W-1:0]   hdr_sync,
  output logic                issue_grant,
  output logic                sync_err,
  input  logic                op_done,
  output logic [REG_ID_W-1:0] reg_rd_id,
  input  logic [SEM_W-1:0]    reg_rd_val,
  input  logic                ext_inc_valid,
  input  logic [IDX_W-1:0]    ext_inc_idx,
  input  logic [IDX_W-1:0]    sem_rd_idx,
  output logic [SEM_W-1:0]    sem_rd_data
);
  logic [1:0]       d_wait_kind;
  logic [IDX_W-1:0] d_wait_idx, d_upd_idx;
  logic [2:0]       d_upd_kind;
  logic [SEM_W-1:0] d_slot;
  logic             d_bad;

  logic [IDX_W-1:0] wait_idx, upd_idx;
  logic [SEM_W-1:0] wait_val, upd_arg;
  logic             upd_v;
  logic [2:0]       upd_op;

  sema_hdr_decode #(.IDX_W(IDX_W), .SEM_W(SEM_W)) u_dec (
    .sync_f(hdr_sync), .wait_kind(d_wait_kind), .wait_idx(d_wait_idx),
    .upd_kind(d_upd_kind), .upd_idx(d_upd_idx), .slot(d_slot), .bad(d_bad));

  sema_seq #(.IDX_W(IDX_W), .SEM_W(SEM_W), .REG_ID_W(REG_ID_W)) u_seq (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .d_wait_kind(d_wait_kind), .d_wait_idx(d_wait_idx), .d_upd_kind(d_upd_kind),
    .d_upd_idx(d_upd_idx), .d_slot(d_slot), .d_bad(d_bad),
    .issue_grant(issue_grant), .sync_err(sync_err), .op_done(op_done),
    .reg_rd_id(reg_rd_id), .reg_rd_val(reg_rd_val),
    .wait_idx(wait_idx), .wait_val(wait_val),
    .upd_v(upd_v), .upd_op(upd_op), .upd_idx(upd_idx), .upd_arg(upd_arg));

  sema_bank #(.N_SEM(N_SEM), .SEM_W(SEM_W)) u_bank (
    .clk(clk), .rst(rst), .wait_idx(wait_idx), .wait_val(wait_val),
    .upd_v(upd_v), .upd_op(upd_op), .upd_idx(upd_idx), .upd_arg(upd_arg),
    .ext_v(ext_inc_valid), .ext_idx(ext_inc_idx),
    .rd_idx(sem_rd_idx), .rd_data(sem_rd_data));
endmodule

// File: tb/sim_sema_sync_unit.sv
module sim_sema_sync_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [63:0] hdr_sync = '0;
  logic        issue_grant, sync_err;
  logic        op_done = 1'b0;
  logic [7:0]  reg_rd_id;
  logic [31:0] reg_rd_val;
  logic        ext_inc_valid = 1'b0;
  logic [4:0]  ext_inc_idx = '0;
  logic [4:0]  sem_rd_idx = '0;
  logic [31:0] sem_rd_data;

  logic [31:0] regfile [256];
  assign reg_rd_val = regfile[reg_rd_id];

  always #4 clk = ~clk;

  sema_sync_unit u0 (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_sync(hdr_sync), .issue_grant(issue_grant), .sync_err(sync_err),
    .op_done(op_done), .reg_rd_id(reg_rd_id), .reg_rd_val(reg_rd_val),
    .ext_inc_valid(ext_inc_valid), .ext_inc_idx(ext_inc_idx),
    .sem_rd_idx(sem_rd_idx), .sem_rd_data(sem_rd_data));

  int checks = 0, errors = 0, cyc = 0;
  bit on = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------- behavioural reference ----------
  int          mstate = 0;
  logic [31:0] msem [32];
  logic [7:0]  mwm, mum;
  logic [4:0]  mwi, mui;
  logic [31:0] mslot;
  bit          mbad, ok;
  bit          exp_grant = 0, exp_err = 0, accepted = 0;
  logic [31:0] exp_rd = '0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mstate = 0; exp_grant = 0; exp_err = 0; exp_rd = '0; accepted = 0;
      for (int i = 0; i < 32; i++) msem[i] = '0;
    end else begin
      exp_rd = msem[sem_rd_idx];
      exp_grant = 0; exp_err = 0; accepted = 0;
      case (mstate)
        0: if (hdr_valid) begin
          mwm = hdr_sync[7:0];   mwi = hdr_sync[12:8];
          mum = hdr_sync[23:16]; mui = hdr_sync[28:24];
          mslot = hdr_sync[63:32];
          mbad = (mwm > 2) || (mum > 4);
          mstate = 1; accepted = 1;
        end
        1: begin
          ok = mbad || mwm == 0 || (mwm == 1 && msem[mwi] >= mslot)
               || (mwm == 2 && msem[mwi] >= regfile[mslot[7:0]]);
          if (ok) begin exp_grant = 1; exp_err = mbad; mstate = 2; end
        end
        default: if (op_done) begin
          if (!mbad) case (mum)
            1: msem[mui] = mslot;
            2: msem[mui] = msem[mui] + mslot;
            3: msem[mui] = msem[mui] + 1;
            4: msem[mui] = msem[mui] - 1;
            default: ;
          endcase
          mstate = 0;
        end
      endcase
      if (ext_inc_valid) msem[ext_inc_idx] = msem[ext_inc_idx] + 1;
    end
  end

  // per-cycle comparison
  always @(negedge clk) if (on) begin
    chk(hdr_ready == (mstate == 0), "R10 hdr_ready", 32'(hdr_ready), 32'(mstate == 0));
    chk(issue_grant == exp_grant, "R3 issue_grant", 32'(issue_grant), 32'(exp_grant));
    chk(sync_err == exp_err, "R9 sync_err", 32'(sync_err), 32'(exp_err));
    chk(sem_rd_data == exp_rd, "R11 sem_rd_data", sem_rd_data, exp_rd);
  end

  always @(posedge clk) if (cyc > 150000) begin
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------- stimulus helpers ----------
  function automatic logic [63:0] build(input logic [7:0] w, input logic [7:0] wi,
    input logic [7:0] u, input logic [7:0] ui, input logic [31:0] s);
    return {s, ui, u, wi, w};
  endfunction

  task automatic send(input logic [7:0] w, input logic [7:0] wi, input logic [7:0] u,
    input logic [7:0] ui, input logic [31:0] s);
    @(negedge clk);
    hdr_valid = 1'b1;
    hdr_sync  = build(w, wi, u, ui, s);
    do @(negedge clk); while (!accepted);
    hdr_valid = 1'b0;
  endtask

  task automatic wait_grant(input string tag);
    int n = 0;
    while (!issue_grant && n < 2000) begin @(negedge clk); n++; end
    chk(issue_grant == 1'b1, tag, 32'(issue_grant), 32'd1);
  endtask

  task automatic finish_op();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  task automatic bump(input logic [4:0] idx);
    @(negedge clk); ext_inc_valid = 1'b1; ext_inc_idx = idx;
    @(negedge clk); ext_inc_valid = 1'b0;
  endtask

  task automatic read_sem(input logic [4:0] idx, input logic [31:0] exp, input string tag);
    @(negedge clk); sem_rd_idx = idx;
    @(negedge clk);
    chk(sem_rd_data == exp, tag, sem_rd_data, exp);
  endtask

  task automatic hold_check(input int n, input string tag);
    repeat (n) begin
      @(negedge clk);
      chk(!issue_grant, tag, 32'(issue_grant), 32'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) regfile[i] = 32'(i * 3);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    on  = 1'b1;

    // R2 reset state
    chk(hdr_ready == 1'b1, "R2 ready after reset", 32'(hdr_ready), 32'd1);
    read_sem(5'd7, 32'd0, "R2 semaphore cleared");

    // R3 no-wait grant timing, R6 set
    send(8'd0, 8'd3, 8'd1, 8'd3, 32'd100);
    @(negedge clk);
    chk(issue_grant == 1'b1, "R3 grant one cycle after acceptance", 32'(issue_grant), 32'd1);
    @(negedge clk);
    chk(issue_grant == 1'b0, "R3 single pulse", 32'(issue_grant), 32'd0);
    finish_op();
    read_sem(5'd3, 32'd100, "R6 set to slot");

    // R6 add
    send(8'd0, 8'd3, 8'd2, 8'd3, 32'd5);
    wait_grant("R3 grant");
    finish_op();
    read_sem(5'd3, 32'd105, "R6 add slot");

    // R4 immediate threshold, R8 external bumps, R7 increment ignores slot
    send(8'd1, 8'd3, 8'd3, 8'd3, 32'd107);
    hold_check(6, "R4 held below threshold");
    bump(5'd3);
    hold_check(3, "R4 held one below threshold");
    bump(5'd3);
    wait_grant("R4 release at threshold");
    finish_op();
    read_sem(5'd3, 32'd108, "R7 increment by one, R8 bumps counted");

    // R5 register threshold re-read, R7 decrement wraps
    regfile[9] = 32'd200;
    send(8'd2, 8'd4, 8'd4, 8'd4, 32'h0000_0109);
    hold_check(5, "R5 held below register value");
    @(negedge clk); regfile[9] = 32'd0;
    wait_grant("R5 register re-read");
    finish_op();
    read_sem(5'd4, 32'hFFFF_FFFF, "R7 decrement wraps");

    // R8 coincident update and external bump
    send(8'd0, 8'd5, 8'd2, 8'd5, 32'd10);
    wait_grant("R8 grant");
    @(negedge clk); op_done = 1'b1; ext_inc_valid = 1'b1; ext_inc_idx = 5'd5;
    @(negedge clk); op_done = 1'b0; ext_inc_valid = 1'b0;
    read_sem(5'd5, 32'd11, "R8 add plus bump");
    send(8'd0, 8'd6, 8'd1, 8'd6, 32'd40);
    wait_grant("R8 grant");
    @(negedge clk); op_done = 1'b1; ext_inc_valid = 1'b1; ext_inc_idx = 5'd6;
    @(negedge clk); op_done = 1'b0; ext_inc_valid = 1'b0;
    read_sem(5'd6, 32'd41, "R8 set plus bump");

    // R9 unknown modes
    send(8'd7, 8'd6, 8'd1, 8'd6, 32'd55);
    @(negedge clk);
    chk(issue_grant && sync_err, "R9 unknown wait mode grants with error",
        {30'd0, issue_grant, sync_err}, 32'd3);
    finish_op();
    read_sem(5'd6, 32'd41, "R9 no update after error");
    send(8'd1, 8'd7, 8'd9, 8'd7, 32'hFFFF_FFFF);
    @(negedge clk);
    chk(issue_grant && sync_err, "R9 unknown update mode skips wait",
        {30'd0, issue_grant, sync_err}, 32'd3);
    finish_op();
    read_sem(5'd7, 32'd0, "R9 unknown update leaves semaphore");

    // R10 completion while idle ignored, header held off while busy
    finish_op();
    read_sem(5'd3, 32'd108, "R10 done while idle ignored");
    send(8'd0, 8'd8, 8'd3, 8'd8, 32'd0);
    wait_grant("R10 grant");
    @(negedge clk);
    hdr_valid = 1'b1; hdr_sync = build(8'd0, 8'd8, 8'd1, 8'd8, 32'd77);
    repeat (4) begin
      @(negedge clk);
      chk(hdr_ready == 1'b0, "R10 not ready while busy", 32'(hdr_ready), 32'd0);
    end
    op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
    do @(negedge clk); while (!accepted);
    hdr_valid = 1'b0;
    wait_grant("R10 queued header granted");
    finish_op();
    read_sem(5'd8, 32'd77, "R10 second header applied after first");

    // R1 byte layout and index truncation
    send(8'd0, 8'hE3, 8'd1, 8'h23, 32'h1122_3344);
    wait_grant("R1 grant");
    finish_op();
    read_sem(5'd3, 32'h1122_3344, "R1 slot byte order and index bits");

    // R11 registered observation
    @(negedge clk); sem_rd_idx = 5'd5;
    chk(sem_rd_data == 32'h1122_3344, "R11 read not yet updated", sem_rd_data, 32'h1122_3344);
    @(negedge clk);
    chk(sem_rd_data == 32'd11, "R11 read one clock later", sem_rd_data, 32'd11);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule